// File: doc/BRIEF.md
# Single-Spare Shift Remapper

This block lets a group of N identical physical elements (logic cells in a subtree, memory subarrays in a bank) appear as a flawless group of N-1 logical elements. A small fault register records which physical element is broken, if any. Every logical slot at or above the broken index is steered one position up, so the broken element never receives a select or write data. The spare is the top physical element, which stays idle while no fault is recorded.

The remap works in both directions. Selects and write data go from logical slots to physical elements. Read results come back from the physical elements to the logical slots, and the broken element's result is dropped. Each group has its own instance and its own fault register, so a chip tolerates one fault per group. A parameter chooses between a registered output stage and a purely combinational path.

Top module: `spare_shift_remap`

## Requirements
- R1: While `rst` is high at a clock edge, the fault record is cleared and `cfg_err` is 0. With REG_OUT=1, `phys_sel`, `phys_wdata` and `log_rdata` are all zero after that edge.
- R2: With no fault recorded, logical slot i drives physical element i. Physical element N-1 gets select 0 and data 0, and logical slot i reads physical element i.
- R3: With fault index f (0 <= f < N) recorded, logical slot i drives physical element i when i < f and element i+1 when i >= f.
- R4: While a fault f is recorded, physical element f always gets select 0 and write data 0.
- R5: With fault f recorded, logical slot i reads physical element i when i < f and element i+1 when i >= f. Element f's read data reaches no logical slot.
- R6: A configuration write with `cfg_valid`=1 and `cfg_idx` >= N sets `cfg_err` to 1. The shift is then disabled and the identity map of R2 applies. Any later configuration write with an index below N, or with `cfg_valid`=0, clears `cfg_err`.
- R7: A configuration write with `cfg_valid`=0 removes the fault record, which restores the identity map.
- R8: With REG_OUT=1, the outputs seen after clock edge k are the map of the inputs sampled at edge k under the fault record held before edge k. A configuration write at edge k therefore affects only data sampled at edge k+1 and later.
- R9: Faults at the boundary indices 0 and N-1 remap correctly. With f=0 every slot shifts up. With f=N-1 the map equals the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Fault register write strobe |
| cfg_valid | input | 1 | 1 records a fault at `cfg_idx`, 0 clears the record |
| cfg_idx | input | IW | Faulty physical index, IW = clog2(N)+1 |
| log_sel | input | N-1 | Per-logical-slot select |
| log_wdata | input | (N-1)*DW | Per-logical-slot write data, slot i in bits [i*DW +: DW] |
| phys_rdata | input | N*DW | Per-physical-element read data |
| phys_sel | output | N | Per-physical-element select |
| phys_wdata | output | N*DW | Per-physical-element write data |
| log_rdata | output | (N-1)*DW | Per-logical-slot read data |
| cfg_err | output | 1 | Out-of-range fault index was written |

## Verification
Two events can happen at the same edge: a fault register write and the capture of a data request. The bench provokes this in directed steps and also lets it occur at random, by raising `cfg_we` in the same cycle that new selects, write data and read data are applied. For each such cycle, the expected outputs are computed from the fault record that was in place before the edge. The new record is then checked against the data of the following cycle.

// File: rtl/spare_pkg.sv
package spare_pkg;
  function automatic int idx_width(input int n);
    return $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/spare_fault_reg.sv
module spare_fault_reg #(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_valid,
  input  logic [IW-1:0] cfg_idx,
  output logic [IW-1:0] fault_idx,
  output logic          shift_act,
  output logic          cfg_err
);
  logic fault_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_idx <= '0;
      fault_vld <= 1'b0;
      cfg_err   <= 1'b0;
    end else if (cfg_we) begin
      fault_idx <= cfg_idx;
      fault_vld <= cfg_valid;
      cfg_err   <= cfg_valid && (cfg_idx >= IW'(N));
    end
  end

  assign shift_act = fault_vld && !cfg_err;
endmodule

// File: rtl/spare_fwd_map.sv
module spare_fwd_map #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic              shift_act,
  input  logic [IW-1:0]     fault_idx,
  input  logic [N-2:0]      log_sel,
  input  logic [(N-1)*DW-1:0] log_wdata,
  output logic [N-1:0]      phys_sel,
  output logic [N*DW-1:0]   phys_wdata
);
  localparam int NL = N - 1;

  for (genvar p = 0; p < N; p++) begin : g_phys
    logic          lo_sel, hi_sel;
    logic [DW-1:0] lo_dat, hi_dat;
    logic          take_lo, take_hi;

    if (p < NL) begin : g_lo
      assign lo_sel = log_sel[p];
      assign lo_dat = log_wdata[p*DW +: DW];
    end else begin : g_nolo
      assign lo_sel = 1'b0;
      assign lo_dat = '0;
    end

    if (p > 0) begin : g_hi
      assign hi_sel = log_sel[p-1];
      assign hi_dat = log_wdata[(p-1)*DW +: DW];
    end else begin : g_nohi
      assign hi_sel = 1'b0;
      assign hi_dat = '0;
    end

    always_comb begin
      take_lo = (p < NL) && (!shift_act || (IW'(p) < fault_idx));
      take_hi = (p > 0) && shift_act && (IW'(p) > fault_idx);
      if (take_lo) begin
        phys_sel[p]              = lo_sel;
        phys_wdata[p*DW +: DW]   = lo_dat;
      end else if (take_hi) begin
        phys_sel[p]              = hi_sel;
        phys_wdata[p*DW +: DW]   = hi_dat;
      end else begin
        phys_sel[p]              = 1'b0;
        phys_wdata[p*DW +: DW]   = '0;
      end
    end
  end
endmodule

// File: rtl/spare_rev_map.sv
module spare_rev_map #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic                shift_act,
  input  logic [IW-1:0]       fault_idx,
  input  logic [N*DW-1:0]     phys_rdata,
  output logic [(N-1)*DW-1:0] log_rdata
);
  for (genvar l = 0; l < N - 1; l++) begin : g_log
    always_comb begin
      if (shift_act && (IW'(l) >= fault_idx))
        log_rdata[l*DW +: DW] = phys_rdata[(l+1)*DW +: DW];
      else
        log_rdata[l*DW +: DW] = phys_rdata[l*DW +: DW];
    end
  end
endmodule

// File: rtl/spare_out_stage.sv
module spare_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_comb
    assign q = d;
  end
endmodule

// File: rtl/spare_shift_remap.sv
module spare_shift_remap
  import spare_pkg::*;
#(
  parameter int N       = 8,
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int IW      = idx_width(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_valid,
  input  logic [IW-1:0]       cfg_idx,
  input  logic [N-2:0]        log_sel,
  input  logic [(N-1)*DW-1:0] log_wdata,
  input  logic [N*DW-1:0]     phys_rdata,
  output logic [N-1:0]        phys_sel,
  output logic [N*DW-1:0]     phys_wdata,
  output logic [(N-1)*DW-1:0] log_rdata,
  output logic                cfg_err
);
  localparam int NL = N - 1;
  localparam int OW = N + N*DW + NL*DW;

  logic [IW-1:0]       fault_idx;
  logic                shift_act;
  logic [N-1:0]        phys_sel_c;
  logic [N*DW-1:0]     phys_wdata_c;
  logic [NL*DW-1:0]    log_rdata_c;

  spare_fault_reg #(.N(N), .IW(IW)) u_freg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_valid(cfg_valid),
    .cfg_idx(cfg_idx), .fault_idx(fault_idx), .shift_act(shift_act),
    .cfg_err(cfg_err)
  );

  spare_fwd_map #(.N(N), .DW(DW), .IW(IW)) u_fwd (
    .shift_act(shift_act), .fault_idx(fault_idx), .log_sel(log_sel),
    .log_wdata(log_wdata), .phys_sel(phys_sel_c), .phys_wdata(phys_wdata_c)
  );

  spare_rev_map #(.N(N), .DW(DW), .IW(IW)) u_rev (
    .shift_act(shift_act), .fault_idx(fault_idx), .phys_rdata(phys_rdata),
    .log_rdata(log_rdata_c)
  );

  spare_out_stage #(.W(OW), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst),
    .d({phys_sel_c, phys_wdata_c, log_rdata_c}),
    .q({phys_sel, phys_wdata, log_rdata})
  );
endmodule

// File: rtl/spare_checker.sv
module spare_checker #(
  parameter int N       = 8,
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int IW      = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic                cfg_valid,
  input logic [IW-1:0]       cfg_idx,
  input logic [N-2:0]        log_sel,
  input logic [N-1:0]        phys_sel,
  input logic [(N-1)*DW-1:0] log_rdata,
  input logic                cfg_err,
  input logic                shift_act,
  input logic [IW-1:0]       fault_idx,
  input logic [N-1:0]        phys_sel_c
);
  a_r1_err_reset: assert property (@(posedge clk) rst |=> !cfg_err);

  a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_valid && cfg_idx >= IW'(N)) |=> cfg_err);

  a_r6_err_identity: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (phys_sel_c == {1'b0, log_sel}));

  a_r4_fault_unused: assert property (@(posedge clk) disable iff (rst)
    shift_act |-> (((phys_sel_c >> fault_idx) & N'(1)) == '0));

  a_r3_sel_count: assert property (@(posedge clk) disable iff (rst)
    $countones(phys_sel_c) == $countones(log_sel));

  if (REG_OUT) begin : g_reg_chk
    a_r1_out_reset: assert property (@(posedge clk)
      rst |=> (phys_sel == '0 && log_rdata == '0));
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ($countones(phys_sel) == $past($countones(log_sel))));
  end
endmodule

bind spare_shift_remap spare_checker #(.N(N), .DW(DW), .REG_OUT(REG_OUT), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_valid(cfg_valid), .cfg_idx(cfg_idx),
  .log_sel(log_sel), .phys_sel(phys_sel), .log_rdata(log_rdata), .cfg_err(cfg_err),
  .shift_act(shift_act), .fault_idx(fault_idx), .phys_sel_c(phys_sel_c)
);

// File: tb/sim_spare_shift_remap.sv
`timescale 1ns/1ps
module sim_spare_shift_remap;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int NL = N - 1;
  localparam int IW = $clog2(N) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [NL-1:0] log_sel = '0;
  logic [NL*DW-1:0] log_wdata = '0;
  logic [N*DW-1:0] phys_rdata = '0;
  logic [N-1:0] phys_sel;
  logic [N*DW-1:0] phys_wdata;
  logic [NL*DW-1:0] log_rdata;
  logic cfg_err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model of the fault record
  int  m_idx = 0;
  bit  m_vld = 1'b0, m_err = 1'b0;

  always #10 clk = ~clk;

  spare_shift_remap #(.N(N), .DW(DW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_valid(cfg_valid), .cfg_idx(cfg_idx),
    .log_sel(log_sel), .log_wdata(log_wdata), .phys_rdata(phys_rdata),
    .phys_sel(phys_sel), .phys_wdata(phys_wdata), .log_rdata(log_rdata), .cfg_err(cfg_err)
  );

  // physical element that logical slot l lands on
  function automatic int dest(input int l, input bit act, input int f);
    return (act && l >= f) ? l + 1 : l;
  endfunction

  function automatic logic [N-1:0] exp_sel(input logic [NL-1:0] s, input bit act, input int f);
    logic [N-1:0] r = '0;
    for (int l = 0; l < NL; l++) r[dest(l, act, f)] = s[l];
    return r;
  endfunction

  function automatic logic [N*DW-1:0] exp_wdata(input logic [NL*DW-1:0] w, input bit act, input int f);
    logic [N*DW-1:0] r = '0;
    for (int l = 0; l < NL; l++) r[dest(l, act, f)*DW +: DW] = w[l*DW +: DW];
    return r;
  endfunction

  function automatic logic [NL*DW-1:0] exp_rdata(input logic [N*DW-1:0] pr, input bit act, input int f);
    logic [NL*DW-1:0] r;
    for (int l = 0; l < NL; l++) r[l*DW +: DW] = pr[dest(l, act, f)*DW +: DW];
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one cycle: apply data (and optionally a config write), then check after the edge
  task automatic step(input bit we, input bit v, input int idx, input string tag);
    bit act;
    logic [NL-1:0] s;
    logic [NL*DW-1:0] w;
    logic [N*DW-1:0] pr;
    @(negedge clk);
    s = NL'($urandom);
    for (int l = 0; l < NL; l++) w[l*DW +: DW] = DW'($urandom);
    for (int p = 0; p < N; p++) pr[p*DW +: DW] = DW'($urandom);
    log_sel = s; log_wdata = w; phys_rdata = pr;
    cfg_we = we; cfg_valid = v; cfg_idx = IW'(idx);
    act = m_vld && !m_err;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (we) begin
      m_idx = idx; m_vld = v; m_err = v && (idx >= N);
    end
    check({tag, " sel"},   128'(phys_sel),   128'(exp_sel(s, act, m_idx_prev(act))));
    check({tag, " wdata"}, 128'(phys_wdata), 128'(exp_wdata(w, act, m_idx_prev(act))));
    check({tag, " rdata"}, 128'(log_rdata),  128'(exp_rdata(pr, act, m_idx_prev(act))));
    check({tag, " cfg_err R6"}, 128'(cfg_err), 128'(m_err));
    pidx = m_idx;
  endtask

  int pidx = 0;  // fault index held before the most recent edge
  function automatic int m_idx_prev(input bit act);
    return act ? pidx : 0;
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    check("R1 phys_sel reset", 128'(phys_sel), 128'(0));
    check("R1 phys_wdata reset", 128'(phys_wdata), 128'(0));
    check("R1 log_rdata reset", 128'(log_rdata), 128'(0));
    check("R1 cfg_err reset", 128'(cfg_err), 128'(0));
    @(negedge clk); rst = 1'b0;

    repeat (4) step(0, 0, 0, "R2 identity");
    step(1, 1, 3, "R8 write same cycle uses old map");
    repeat (6) step(0, 0, 0, "R3 R4 R5 fault 3");
    step(1, 1, 0, "R8 switch to fault 0");
    repeat (4) step(0, 0, 0, "R9 fault 0");
    step(1, 1, N-1, "R8 switch to fault N-1");
    repeat (4) step(0, 0, 0, "R9 fault N-1");
    step(1, 1, 9, "R6 out-of-range write");
    repeat (3) step(0, 0, 0, "R6 identity under error");
    step(1, 1, 5, "R6 error cleared by valid write");
    repeat (2) step(0, 0, 0, "R3 R5 fault 5");
    step(1, 0, 5, "R7 clear record");
    repeat (3) step(0, 0, 0, "R7 identity after clear");

    for (int k = 0; k < 400; k++) begin
      bit we = ($urandom % 8) == 0;
      step(we, ($urandom % 4) != 0, int'($urandom % 12), "R3 R4 R5 R8 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule